// File: doc/BRIEF.md
# Windowed Hierarchical Interrupt Status Unit

This block gathers interrupt events for four endpoints of a USB device controller: the control endpoint and three further endpoints, here called A, B and C. Each endpoint owns an 8-bit register. A one-cycle pulse on one of that endpoint's source lines sets the matching bit, and the bit stays set until software clears it. A read-only summary byte carries one bit per endpoint. That bit is the OR of the endpoint's latched bits, so it drops by itself once the last of them has been cleared. A single interrupt line is the OR of the summary bits.

The endpoint registers have no addresses of their own. Two byte-wide status windows show them instead, and an index register picks the endpoint that each window shows. Software reads a window and then writes the same value back to it. Every 1 in the written byte clears that bit in the endpoint the window currently selects. A bit written as 0 is left alone. The register bus is byte-wide, has one address port and a write strobe, and returns read data combinationally.

Top module: `irq_window_top`

## Requirements
- R1: After reset every endpoint register and the index register hold 0, every mapped address reads 0x00, and `irq_out` is low.
- R2: A high bit on `src_pulse[8*e+b]` in a cycle sets bit b of endpoint e's register at that clock edge. The bit stays set while no clear reaches it, and it never sets without a pulse.
- R3: Address 0x01 reads the summary. Bit 0 is the control endpoint, bits 1, 2 and 3 are endpoints A, B and C, and each bit is high exactly when its endpoint register is non-zero. Bits 7:4 read 0.
- R4: A summary bit falls only once every bit of its endpoint has been cleared. Writes to address 0x01 change nothing.
- R5: The index register at address 0x08 holds the window 0 selector in bits 1:0 and the window 1 selector in bits 5:4. Selector values 0, 1, 2 and 3 mean the control endpoint, A, B and C. The register reads back as written, and bits 7:6 and 3:2 read 0.
- R6: Address 0x02 (window 0) and address 0x03 (window 1) each read the full register of the endpoint chosen by their own selector.
- R7: A write to a window clears each bit written as 1 in the selected endpoint only. Bits written as 0, and all other endpoints, keep their values.
- R8: When a source pulse and a window clear hit the same bit in the same cycle, the bit ends up set.
- R9: `irq_out` is high exactly when at least one summary bit is high.
- R10: Addresses that are not mapped read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| src_pulse | input | 32 | Event pulses; bits 8e+7..8e belong to endpoint e (0 control, 1 A, 2 B, 3 C) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bound checker watches every latched bit on every cycle: it sets on a pulse, holds without a clear, and falls on a clear that no pulse opposes. It also checks that set wins over clear, that the interrupt line matches the OR of the endpoint registers, and that reserved summary and index bits read zero. It builds its own clear condition from the bus ports and the selectors. What only the bench's scenarios can show is the window routing: which endpoint each selector value reaches, that a clear through one window leaves the other endpoints alone, that the summary holds while some bits remain, and that writes to the summary address are ignored.

// File: rtl/irq_win_pkg.sv
package irq_win_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 8;
    localparam int NUM_EP     = 4;
    localparam int NUM_WIN    = 2;
    localparam int SEL_W      = $clog2(NUM_EP);
    localparam int SEL_STRIDE = 4;
    localparam int WIN_IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    localparam logic [ADDR_W-1:0] ADR_SUMMARY  = 8'h01;
    localparam logic [ADDR_W-1:0] ADR_WIN_BASE = 8'h02;
    localparam logic [ADDR_W-1:0] ADR_INDEX    = 8'h08;

    typedef logic [DATA_W-1:0]             byte_t;
    typedef logic [SEL_W-1:0]              ep_sel_t;
    typedef logic [NUM_EP-1:0][DATA_W-1:0] ep_status_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SUMMARY,
        ACC_WINDOW,
        ACC_INDEX
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t            kind;
        logic [WIN_IDX_W-1:0] win;
    } acc_dec_t;

    function automatic byte_t idx_field_mask();
        byte_t m;
        m = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            m[w*SEL_STRIDE +: SEL_W] = '1;
        end
        return m;
    endfunction

    localparam byte_t IDX_MASK = idx_field_mask();

    function automatic acc_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        acc_dec_t d;
        d.kind = ACC_NONE;
        d.win  = '0;
        if (a == ADR_SUMMARY) begin
            d.kind = ACC_SUMMARY;
        end else if (a == ADR_INDEX) begin
            d.kind = ACC_INDEX;
        end else begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (a == ADR_WIN_BASE + ADDR_W'(w)) begin
                    d.kind = ACC_WINDOW;
                    d.win  = WIN_IDX_W'(w);
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_ep_status.sv
module irq_ep_status
    import irq_win_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t set_i,
    input  byte_t clr_i,
    output byte_t status_o,
    output logic  any_o
);

    byte_t status_q;

    // Set wins: the pulse is OR-ed in after the clear mask
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_i) | set_i;
        end
    end

    assign status_o = status_q;
    assign any_o    = |status_q;

endmodule

// File: rtl/irq_index_reg.sv
module irq_index_reg
    import irq_win_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  byte_t                  wdata,
    output byte_t                  rdata_o,
    output ep_sel_t [NUM_WIN-1:0]  sel_o
);

    byte_t idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (wr_en) begin
            idx_q <= wdata & IDX_MASK;
        end
    end

    assign rdata_o = idx_q;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_sel
        assign sel_o[w] = idx_q[w*SEL_STRIDE +: SEL_W];
    end

endmodule

// File: rtl/irq_window_port.sv
module irq_window_port
    import irq_win_pkg::*;
(
    input  ep_status_t st_i,
    input  ep_sel_t    sel_i,
    input  logic       wr_hit_i,
    input  byte_t      wdata_i,
    output byte_t      view_o,
    output ep_status_t clr_o
);

    assign view_o = st_i[sel_i];

    for (genvar e = 0; e < NUM_EP; e++) begin : g_clr
        assign clr_o[e] = (wr_hit_i && (sel_i == ep_sel_t'(e))) ? wdata_i : '0;
    end

endmodule

// File: rtl/irq_window_top.sv
module irq_window_top
    import irq_win_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic                     reg_wr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [NUM_EP*DATA_W-1:0] src_pulse,
    output logic                     irq_out
);

    localparam int SRC_W = NUM_EP * DATA_W;

    acc_dec_t                           dec;
    ep_status_t                         ep_status;
    logic [NUM_EP-1:0]                  ep_summary;
    ep_status_t                         clr_all;
    logic [NUM_WIN-1:0][NUM_EP-1:0][DATA_W-1:0] win_clr;
    byte_t [NUM_WIN-1:0]                win_view;
    logic  [NUM_WIN-1:0]                win_hit;
    ep_sel_t [NUM_WIN-1:0]              win_sel;
    byte_t                              idx_rdata;
    logic                               idx_wr;
    logic [SRC_W-1:0]                   ep_status_flat;

    assign dec    = decode_addr(reg_addr);
    assign idx_wr = reg_wr && (dec.kind == ACC_INDEX);

    irq_index_reg u_index (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (idx_wr),
        .wdata   (reg_wdata),
        .rdata_o (idx_rdata),
        .sel_o   (win_sel)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign win_hit[w] = reg_wr && (dec.kind == ACC_WINDOW) &&
                            (dec.win == WIN_IDX_W'(w));

        irq_window_port u_port (
            .st_i     (ep_status),
            .sel_i    (win_sel[w]),
            .wr_hit_i (win_hit[w]),
            .wdata_i  (reg_wdata),
            .view_o   (win_view[w]),
            .clr_o    (win_clr[w])
        );
    end

    always_comb begin
        clr_all = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            clr_all = clr_all | win_clr[w];
        end
    end

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        irq_ep_status u_ep (
            .clk      (clk),
            .rst      (rst),
            .set_i    (src_pulse[e*DATA_W +: DATA_W]),
            .clr_i    (clr_all[e]),
            .status_o (ep_status[e]),
            .any_o    (ep_summary[e])
        );
    end

    assign ep_status_flat = ep_status;
    assign irq_out        = |ep_summary;

    always_comb begin
        unique case (dec.kind)
            ACC_SUMMARY: reg_rdata = byte_t'(ep_summary);
            ACC_WINDOW:  reg_rdata = win_view[dec.win];
            ACC_INDEX:   reg_rdata = idx_rdata;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_window_chk.sv
module irq_window_chk
    import irq_win_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic                     reg_wr,
    input logic [DATA_W-1:0]        reg_wdata,
    input logic [DATA_W-1:0]        reg_rdata,
    input logic [NUM_EP*DATA_W-1:0] src_pulse,
    input logic                     irq_out,
    input logic [NUM_EP*DATA_W-1:0] ep_status,
    input ep_sel_t [NUM_WIN-1:0]    sel
);

    logic [NUM_EP*DATA_W-1:0] clr_hit;

    always_comb begin
        clr_hit = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (reg_wr && reg_addr == ADR_WIN_BASE + ADDR_W'(w)) begin
                clr_hit[int'(sel[w])*DATA_W +: DATA_W] =
                    clr_hit[int'(sel[w])*DATA_W +: DATA_W] | reg_wdata;
            end
        end
    end

    for (genvar i = 0; i < NUM_EP*DATA_W; i++) begin : g_bit
        AST_PULSE_SETS: assert property (@(posedge clk) disable iff (rst)
            src_pulse[i] |=> ep_status[i]);                          // R8
        AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (ep_status[i] && !clr_hit[i]) |=> ep_status[i]);         // R2
        AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
            (!ep_status[i] && !src_pulse[i]) |=> !ep_status[i]);     // R2
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr_hit[i] && !src_pulse[i]) |=> !ep_status[i]);        // R7
    end

    for (genvar e = 0; e < NUM_EP; e++) begin : g_sum
        AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (rst)
            (reg_addr == ADR_SUMMARY) |->
                (reg_rdata[e] == (ep_status[e*DATA_W +: DATA_W] != '0))); // R3
    end

    AST_IRQ_LINE: assert property (@(posedge clk) disable iff (rst)
        irq_out == (ep_status != '0));                               // R9
    AST_SUMMARY_RSV: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADR_SUMMARY) |-> (reg_rdata[DATA_W-1:NUM_EP] == '0)); // R3
    AST_INDEX_RSV: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADR_INDEX) |-> ((reg_rdata & ~IDX_MASK) == '0)); // R5

endmodule

bind irq_window_top irq_window_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_pulse (src_pulse),
    .irq_out   (irq_out),
    .ep_status (ep_status_flat),
    .sel       (win_sel)
);

// File: tb/irq_window_top_tb_top.sv
module irq_window_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [31:0] src_pulse = '0;
    logic        irq_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    irq_window_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_pulse (src_pulse),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One clock cycle of stimulus, applied between edges
    task automatic cycle(input logic [7:0] a, input logic w, input logic [7:0] d,
                         input logic [31:0] p);
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d; src_pulse = p;
        @(negedge clk);
        reg_wr = 1'b0; src_pulse = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cycle(a, 1'b1, d, 32'h0);
    endtask

    task automatic pulse(input logic [31:0] p);
        cycle(8'h00, 1'b0, 8'h00, p);
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic t_reset();
        rd_check("R1 summary", 8'h01, 8'h00);
        rd_check("R1 window0", 8'h02, 8'h00);
        rd_check("R1 window1", 8'h03, 8'h00);
        rd_check("R1 index",   8'h08, 8'h00);
        check("R1 irq", {7'b0, irq_out}, 8'h00);
        rd_check("R10 addr04", 8'h04, 8'h00);
        rd_check("R10 addr05", 8'h05, 8'h00);
    endtask

    task automatic t_latch();
        pulse(32'h0000_0800);           // endpoint A bit 3
        wr(8'h08, 8'h01);               // window0 -> A, window1 -> control
        rd_check("R6 win0 A", 8'h02, 8'h08);
        rd_check("R6 win1 ctl", 8'h03, 8'h00);
        rd_check("R3 summary A", 8'h01, 8'h02);
        check("R9 irq high", {7'b0, irq_out}, 8'h01);
        repeat (5) @(negedge clk);
        rd_check("R2 held", 8'h02, 8'h08);
    endtask

    task automatic t_index();
        wr(8'h08, 8'hFF);
        rd_check("R5 masked readback", 8'h08, 8'h33);
        wr(8'h08, 8'h30);
        rd_check("R5 readback", 8'h08, 8'h30);
    endtask

    task automatic t_two_windows();
        pulse(32'h8100_0010);           // C: 0x81, control: 0x10
        rd_check("R6 win0 ctl", 8'h02, 8'h10);
        rd_check("R6 win1 C", 8'h03, 8'h81);
        rd_check("R3 summary three", 8'h01, 8'h0B);
    endtask

    task automatic t_clear();
        wr(8'h08, 8'h13);               // window0 -> C, window1 -> A
        wr(8'h02, 8'h01);
        rd_check("R7 partial clear", 8'h02, 8'h80);
        rd_check("R7 other ep kept", 8'h03, 8'h08);
        rd_check("R4 summary holds", 8'h01, 8'h0B);
        wr(8'h02, 8'h80);
        rd_check("R7 C cleared", 8'h02, 8'h00);
        rd_check("R4 summary falls", 8'h01, 8'h03);
        wr(8'h03, 8'h08);
        rd_check("R7 window1 clear", 8'h03, 8'h00);
        rd_check("R4 summary ctl only", 8'h01, 8'h01);
        wr(8'h08, 8'h00);
        rd_check("R7 ctl untouched", 8'h02, 8'h10);
    endtask

    task automatic t_summary_write();
        wr(8'h01, 8'hFF);
        rd_check("R4 summary write ignored", 8'h01, 8'h01);
        rd_check("R4 ctl after summary write", 8'h02, 8'h10);
    endtask

    task automatic t_collision();
        wr(8'h08, 8'h02);               // window0 -> B
        pulse(32'h0006_0000);
        rd_check("R2 B latched", 8'h02, 8'h06);
        cycle(8'h02, 1'b1, 8'h06, 32'h0004_0000);
        rd_check("R8 set beats clear", 8'h02, 8'h04);
    endtask

    task automatic t_drain();
        wr(8'h02, 8'h04);
        wr(8'h08, 8'h00);
        check("R9 irq still high", {7'b0, irq_out}, 8'h01);
        wr(8'h02, 8'h10);
        rd_check("R3 summary empty", 8'h01, 8'h00);
        check("R9 irq low", {7'b0, irq_out}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latch();
        t_index();
        t_two_windows();
        t_clear();
        t_summary_write();
        t_collision();
        t_drain();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #40000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule